// File: doc/BRIEF.md
# Protection and Fault Sequencer

This block is the supervisory state machine of a primary-side switching power controller. It takes comparator flags that are already digital: supply levels, dimming level, line, die temperature, sense-pin impedance, per-cycle over-current, auxiliary-winding short and an externally set over-voltage trip. From these it decides when the gate driver may switch, when the chip rests in low-power mode, and when the current-sense impedance check is requested. A switching-cycle strobe and a one-millisecond tick pace the counters, so every wait is a number of milliseconds set by a parameter.

Seven states are used. POWERUP waits for the supply. SLEEP is the low-power idle. CHECK holds the impedance request. RUN is the only state that drives the gate. RECOVER waits out a fault before returning to SLEEP. ADJWAIT waits after an adjustable over-voltage trip and returns to CHECK. HALT holds a latched fault. The named transitions are: POWERUP→SLEEP (supply up), SLEEP→CHECK (wake), CHECK→RUN (check passed), CHECK→RECOVER (sense short), RUN→HALT or RUN→RECOVER (hard fault, depending on `LATCHED`), RUN→ADJWAIT (adjustable trip), RUN→RECOVER (aux short), RECOVER→SLEEP and ADJWAIT→CHECK (timer expiry), any active state→SLEEP (drop or long dim-low), HALT→SLEEP (unlatch), and any state→POWERUP (logic reset level).

Top module: `prot_sequencer`

## Requirements
- R1: After reset the block is in POWERUP with `gate_en`, `sleep` and `imp_start` all low. It moves to SLEEP once `sup_on` is high.
- R2: In SLEEP, `sleep` is high. SLEEP moves to CHECK only when `sup_on` and `dim_above_hys` are high, and `sup_low`, `line_low` and `therm_hot` are low. `dim_above` alone does not wake it.
- R3: In CHECK, `imp_start` is high. `imp_done` with `imp_short` low moves to RUN. `imp_done` with `imp_short` high moves to RECOVER.
- R4: `gate_en` is high only in RUN, and only while `dim_above` is high.
- R5: RECOVER lasts `AR_MS` ticks of `ms_tick`. It then moves to SLEEP, never straight to RUN.
- R6: `line_low`, `therm_hot` or `sup_low` moves any of CHECK, RUN, RECOVER or ADJWAIT to SLEEP. `sup_rst` moves any state to POWERUP.
- R7: An over-current stop is declared after `OC_CYCLES` consecutive `sw_cycle` strobes with `oc_stop` high in RUN. A strobe with `oc_stop` low clears the count, and so does leaving RUN.
- R8: With `LATCHED`=1, a supply over-voltage (`sup_ovp`) or an over-current stop in RUN enters HALT. With `LATCHED`=0, the same faults enter RECOVER.
- R9: HALT moves to SLEEP on `sup_low`, on `line_low`, or on `dim_above` held low for `DIM_OFF_MS` ticks. It ignores `imp_done` and every other input.
- R10: `adj_ovp` in RUN enters ADJWAIT. After `ADJ_WAIT_LATCHED_MS` ticks (`LATCHED`=1) or `ADJ_WAIT_AUTO_MS` ticks (`LATCHED`=0), ADJWAIT moves to CHECK, not to SLEEP.
- R11: `dim_above` held low for `DIM_OFF_MS` ticks in CHECK, RUN or HALT moves to SLEEP. The count restarts whenever `dim_above` returns high.
- R12: `zcd_short` in RUN enters RECOVER when `dim_above` is high. It is ignored while `dim_above` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sup_rst | input | 1 | Supply below the logic reset level |
| sup_on | input | 1 | Supply above the turn-on level |
| sup_low | input | 1 | Supply below the minimum operating level |
| sup_ovp | input | 1 | Supply over-voltage |
| dim_above | input | 1 | Dim input above its enable level |
| dim_above_hys | input | 1 | Dim input above enable level plus hysteresis |
| line_low | input | 1 | Line brown-out, not ok |
| therm_hot | input | 1 | Thermal shutdown active |
| imp_done | input | 1 | Impedance check finished |
| imp_short | input | 1 | Impedance check found a sense-pin short |
| oc_stop | input | 1 | Sense signal above the stop threshold in this cycle |
| sw_cycle | input | 1 | One-clock strobe per switching cycle |
| zcd_short | input | 1 | Confirmed auxiliary-winding or output short |
| adj_ovp | input | 1 | Adjustable over-voltage trip |
| ms_tick | input | 1 | One-clock strobe every millisecond |
| gate_en | output | 1 | Gate drive allowed |
| sleep | output | 1 | Low-power mode |
| imp_start | output | 1 | Impedance check request |

## Verification
The bench builds two copies side by side, one with `LATCHED`=1 and one with `LATCHED`=0. Both use short windows: 8 ticks of recovery, 6 and 3 ticks of adjustable over-voltage wait, 5 ticks of dim-low and 4 over-current cycles. Because both copies get the same stimulus, each fault shows the latched path and the auto-recovery path in the same steps. The short windows bring every timer expiry, the count one short of each limit and the restart of each count within a few hundred clocks.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP = 3'd0,
        ST_SLEEP   = 3'd1,
        ST_CHECK   = 3'd2,
        ST_RUN     = 3'd3,
        ST_RECOVER = 3'd4,
        ST_ADJWAIT = 3'd5,
        ST_HALT    = 3'd6
    } psc_state_e;

    function automatic int unsigned psc_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psc_ms_timer.sv
module psc_ms_timer #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q >= limit);

endmodule

// File: rtl/psc_oc_count.sv
module psc_oc_count #(
    parameter int unsigned CYCLES = 4,
    localparam int unsigned W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic strobe,
    input  logic over,
    output logic trip
);

    localparam logic [W-1:0] LIMIT = W'(CYCLES);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!arm) begin
            cnt_q <= '0;
        end else if (strobe) begin
            if (!over) begin
                cnt_q <= '0;
            end else if (cnt_q < LIMIT) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign trip = arm && (cnt_q >= LIMIT);

endmodule

// File: rtl/prot_sequencer.sv
module prot_sequencer
    import psc_pkg::*;
#(
    parameter bit          LATCHED             = 1'b1,
    parameter int unsigned AR_MS               = 4000,
    parameter int unsigned ADJ_WAIT_LATCHED_MS = 4000,
    parameter int unsigned ADJ_WAIT_AUTO_MS    = 1000,
    parameter int unsigned DIM_OFF_MS          = 4000,
    parameter int unsigned OC_CYCLES           = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_rst,
    input  logic sup_on,
    input  logic sup_low,
    input  logic sup_ovp,
    input  logic dim_above,
    input  logic dim_above_hys,
    input  logic line_low,
    input  logic therm_hot,
    input  logic imp_done,
    input  logic imp_short,
    input  logic oc_stop,
    input  logic sw_cycle,
    input  logic zcd_short,
    input  logic adj_ovp,
    input  logic ms_tick,
    output logic gate_en,
    output logic sleep,
    output logic imp_start
);

    localparam int unsigned ADJ_MS  = LATCHED ? ADJ_WAIT_LATCHED_MS : ADJ_WAIT_AUTO_MS;
    localparam int unsigned TMR_MAX = psc_max(AR_MS, ADJ_MS);
    localparam int unsigned TW      = $clog2(TMR_MAX + 1);
    localparam int unsigned DW      = $clog2(DIM_OFF_MS + 1);

    psc_state_e state_q, state_d;
    psc_state_e hard_dst;

    logic          wait_run, wait_done;
    logic [TW-1:0] wait_limit;
    logic          dim_run, dim_done, dim_trip;
    logic          oc_trip;
    logic          drop;

    // Destination of supply over-voltage and over-current stop
    generate
        if (LATCHED) begin : g_latch_dst
            assign hard_dst = ST_HALT;
        end else begin : g_auto_dst
            assign hard_dst = ST_RECOVER;
        end
    endgenerate

    // Fault wait timer, shared by RECOVER and ADJWAIT (never adjacent)
    assign wait_run   = (state_q == ST_RECOVER) || (state_q == ST_ADJWAIT);
    assign wait_limit = (state_q == ST_RECOVER) ? TW'(AR_MS) : TW'(ADJ_MS);

    psc_ms_timer #(.W(TW)) u_wait_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wait_run),
        .tick  (ms_tick),
        .limit (wait_limit),
        .done  (wait_done)
    );

    // Dim-low timer
    assign dim_run = !dim_above &&
                     ((state_q == ST_CHECK) || (state_q == ST_RUN) || (state_q == ST_HALT));

    psc_ms_timer #(.W(DW)) u_dim_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (dim_run),
        .tick  (ms_tick),
        .limit (DW'(DIM_OFF_MS)),
        .done  (dim_done)
    );

    assign dim_trip = dim_done && !dim_above;

    // Consecutive over-current cycle counter
    psc_oc_count #(.CYCLES(OC_CYCLES)) u_oc_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (state_q == ST_RUN),
        .strobe (sw_cycle),
        .over   (oc_stop),
        .trip   (oc_trip)
    );

    assign drop = sup_low || line_low || therm_hot;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POWERUP: begin
                if (sup_on) state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (sup_on && dim_above_hys && !drop) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (drop || dim_trip)  state_d = ST_SLEEP;
                else if (imp_done)     state_d = imp_short ? ST_RECOVER : ST_RUN;
            end
            ST_RUN: begin
                if (drop)                          state_d = ST_SLEEP;
                else if (sup_ovp || oc_trip)       state_d = hard_dst;
                else if (adj_ovp)                  state_d = ST_ADJWAIT;
                else if (zcd_short && dim_above)   state_d = ST_RECOVER;
                else if (dim_trip)                 state_d = ST_SLEEP;
            end
            ST_RECOVER: begin
                if (drop || wait_done) state_d = ST_SLEEP;
            end
            ST_ADJWAIT: begin
                if (drop)           state_d = ST_SLEEP;
                else if (wait_done) state_d = ST_CHECK;
            end
            ST_HALT: begin
                if (sup_low || line_low || dim_trip) state_d = ST_SLEEP;
            end
            default: state_d = ST_POWERUP;
        endcase
        if (sup_rst) state_d = ST_POWERUP;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_POWERUP;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        gate_en   = 1'b0;
        sleep     = 1'b0;
        imp_start = 1'b0;
        unique case (state_q)
            ST_SLEEP: sleep     = 1'b1;
            ST_CHECK: imp_start = 1'b1;
            ST_RUN:   gate_en   = dim_above;
            default: ;
        endcase
    end

endmodule

// File: rtl/psc_chk.sv
module psc_chk
    import psc_pkg::*;
#(
    parameter bit          LATCHED    = 1'b1,
    parameter int unsigned AR_MS      = 4000,
    parameter int unsigned OC_CYCLES  = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sup_rst,
    input logic       sup_low,
    input logic       sup_ovp,
    input logic       dim_above,
    input logic       dim_above_hys,
    input logic       line_low,
    input logic       therm_hot,
    input logic       oc_stop,
    input logic       sw_cycle,
    input logic       ms_tick,
    input logic       gate_en,
    input logic       sleep,
    input logic       imp_start,
    input psc_state_e state_q
);

    int unsigned oc_seen;
    int unsigned rec_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oc_seen   <= 0;
            rec_ticks <= 0;
        end else begin
            if (state_q != ST_RUN)   oc_seen <= 0;
            else if (sw_cycle)       oc_seen <= oc_stop ? oc_seen + 1 : 0;
            if (state_q != ST_RECOVER) rec_ticks <= 0;
            else if (ms_tick)          rec_ticks <= rec_ticks + 1;
        end
    end

    // R1
    reset_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sup_rst |=> (!gate_en && !sleep && !imp_start));

    // R6
    line_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_low |=> !gate_en);

    // R3
    gate_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> ($past(imp_start) || !$past(dim_above)));

    // R2
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep) |-> ($past(dim_above_hys) || $past(sup_rst)));

    // R7
    oc_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (oc_seen <= OC_CYCLES));

    // R5
    recover_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER) |-> (rec_ticks <= AR_MS));

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !sup_low && !line_low && !sup_rst && dim_above)
        |=> (state_q == ST_HALT));

    // R8
    ovp_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sup_ovp && !sup_rst && !sup_low && !line_low && !therm_hot)
        |=> (state_q == (LATCHED ? ST_HALT : ST_RECOVER)));

endmodule

bind prot_sequencer psc_chk #(
    .LATCHED   (LATCHED),
    .AR_MS     (AR_MS),
    .OC_CYCLES (OC_CYCLES)
) u_psc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sup_rst       (sup_rst),
    .sup_low       (sup_low),
    .sup_ovp       (sup_ovp),
    .dim_above     (dim_above),
    .dim_above_hys (dim_above_hys),
    .line_low      (line_low),
    .therm_hot     (therm_hot),
    .oc_stop       (oc_stop),
    .sw_cycle      (sw_cycle),
    .ms_tick       (ms_tick),
    .gate_en       (gate_en),
    .sleep         (sleep),
    .imp_start     (imp_start),
    .state_q       (state_q)
);

// File: tb/prot_sequencer_tb.sv
module prot_sequencer_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_rst = 0, sup_on = 0, sup_low = 0, sup_ovp = 0;
    logic dim_above = 0, dim_above_hys = 0, line_low = 0, therm_hot = 0;
    logic imp_done = 0, imp_short = 0, oc_stop = 0, zcd_short = 0, adj_ovp = 0;
    logic sw_cycle = 0, ms_tick = 0;
    logic gate_l, sleep_l, imp_l;
    logic gate_a, sleep_a, imp_a;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    prot_sequencer #(
        .LATCHED(1'b1), .AR_MS(8), .ADJ_WAIT_LATCHED_MS(6), .ADJ_WAIT_AUTO_MS(3),
        .DIM_OFF_MS(5), .OC_CYCLES(4)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sup_rst(sup_rst), .sup_on(sup_on), .sup_low(sup_low),
        .sup_ovp(sup_ovp), .dim_above(dim_above), .dim_above_hys(dim_above_hys),
        .line_low(line_low), .therm_hot(therm_hot), .imp_done(imp_done), .imp_short(imp_short),
        .oc_stop(oc_stop), .sw_cycle(sw_cycle), .zcd_short(zcd_short), .adj_ovp(adj_ovp),
        .ms_tick(ms_tick), .gate_en(gate_l), .sleep(sleep_l), .imp_start(imp_l)
    );

    prot_sequencer #(
        .LATCHED(1'b0), .AR_MS(8), .ADJ_WAIT_LATCHED_MS(6), .ADJ_WAIT_AUTO_MS(3),
        .DIM_OFF_MS(5), .OC_CYCLES(4)
    ) u_dut_ar (
        .clk(clk), .rst_n(rst_n), .sup_rst(sup_rst), .sup_on(sup_on), .sup_low(sup_low),
        .sup_ovp(sup_ovp), .dim_above(dim_above), .dim_above_hys(dim_above_hys),
        .line_low(line_low), .therm_hot(therm_hot), .imp_done(imp_done), .imp_short(imp_short),
        .oc_stop(oc_stop), .sw_cycle(sw_cycle), .zcd_short(zcd_short), .adj_ovp(adj_ovp),
        .ms_tick(ms_tick), .gate_en(gate_a), .sleep(sleep_a), .imp_start(imp_a)
    );

    // Row: {req, inputs, strobes, ticks, expected latched, expected auto}
    // inputs: {sup_rst sup_on sup_low sup_ovp}_{dim_above dim_above_hys}_{line_low therm_hot}
    //         _{imp_done imp_short}_{oc_stop zcd_short adj_ovp}
    // expected: {gate_en, sleep, imp_start}
    localparam int NV = 55;
    localparam logic [29:0] VEC [NV] = '{
        {4'd1,  13'b0000_00_00_00_000, 3'd0, 4'd0, 3'b000, 3'b000}, // R1 stay in POWERUP
        {4'd1,  13'b0100_00_00_00_000, 3'd0, 4'd0, 3'b010, 3'b010}, // R1 supply up
        {4'd2,  13'b0100_10_00_00_000, 3'd0, 4'd0, 3'b010, 3'b010}, // R2 inside hysteresis
        {4'd2,  13'b0100_11_00_00_000, 3'd0, 4'd0, 3'b001, 3'b001}, // R2 wake
        {4'd3,  13'b0100_11_00_10_000, 3'd0, 4'd0, 3'b100, 3'b100}, // R3 pass
        {4'd7,  13'b0100_11_00_00_100, 3'd3, 4'd0, 3'b100, 3'b100}, // R7 three over
        {4'd7,  13'b0100_11_00_00_000, 3'd1, 4'd0, 3'b100, 3'b100}, // R7 clean cycle
        {4'd7,  13'b0100_11_00_00_100, 3'd3, 4'd0, 3'b100, 3'b100}, // R7 restarted
        {4'd8,  13'b0100_11_00_00_100, 3'd1, 4'd0, 3'b000, 3'b000}, // R8 oc stop
        {4'd5,  13'b0100_11_00_00_000, 3'd0, 4'd7, 3'b000, 3'b000}, // R5 one short
        {4'd5,  13'b0100_11_00_00_000, 3'd0, 4'd1, 3'b000, 3'b001}, // R5 expiry
        {4'd9,  13'b0100_11_00_10_000, 3'd0, 4'd0, 3'b000, 3'b100}, // R9 halt ignores done
        {4'd9,  13'b0100_11_10_00_000, 3'd0, 4'd0, 3'b010, 3'b010}, // R9 line unlatch
        {4'd6,  13'b0100_11_00_00_000, 3'd0, 4'd0, 3'b001, 3'b001}, // R6 line back
        {4'd3,  13'b0100_11_00_10_000, 3'd0, 4'd0, 3'b100, 3'b100}, // R3
        {4'd8,  13'b0101_11_00_00_000, 3'd0, 4'd0, 3'b000, 3'b000}, // R8 supply ovp
        {4'd9,  13'b0100_00_00_00_000, 3'd0, 4'd4, 3'b000, 3'b000}, // R9 dim low 4
        {4'd9,  13'b0100_00_00_00_000, 3'd0, 4'd1, 3'b010, 3'b000}, // R9 dim unlatch
        {4'd5,  13'b0100_00_00_00_000, 3'd0, 4'd3, 3'b010, 3'b010}, // R5 recover ends
        {4'd2,  13'b0100_11_00_00_000, 3'd0, 4'd0, 3'b001, 3'b001}, // R2
        {4'd3,  13'b0100_11_00_11_000, 3'd0, 4'd0, 3'b000, 3'b000}, // R3 sense short
        {4'd5,  13'b0100_11_00_00_000, 3'd0, 4'd8, 3'b001, 3'b001}, // R5
        {4'd3,  13'b0100_11_00_10_000, 3'd0, 4'd0, 3'b100, 3'b100}, // R3
        {4'd10, 13'b0100_11_00_00_001, 3'd0, 4'd0, 3'b000, 3'b000}, // R10 trip
        {4'd10, 13'b0100_11_00_00_000, 3'd0, 4'd3, 3'b000, 3'b001}, // R10 short wait
        {4'd10, 13'b0100_11_00_00_000, 3'd0, 4'd3, 3'b001, 3'b001}, // R10 long wait
        {4'd3,  13'b0100_11_00_10_000, 3'd0, 4'd0, 3'b100, 3'b100}, // R3
        {4'd4,  13'b0100_00_00_00_000, 3'd0, 4'd4, 3'b000, 3'b000}, // R4 dim gates drive
        {4'd11, 13'b0100_11_00_00_000, 3'd0, 4'd0, 3'b100, 3'b100}, // R11 dim back
        {4'd11, 13'b0100_00_00_00_000, 3'd0, 4'd4, 3'b000, 3'b000}, // R11 count restarted
        {4'd11, 13'b0100_00_00_00_000, 3'd0, 4'd1, 3'b010, 3'b010}, // R11 to sleep
        {4'd2,  13'b0100_11_00_00_000, 3'd0, 4'd0, 3'b001, 3'b001}, // R2
        {4'd3,  13'b0100_11_00_10_000, 3'd0, 4'd0, 3'b100, 3'b100}, // R3
        {4'd6,  13'b0100_11_01_00_000, 3'd0, 4'd0, 3'b010, 3'b010}, // R6 hot
        {4'd6,  13'b0100_11_01_00_000, 3'd0, 4'd0, 3'b010, 3'b010}, // R6 still hot
        {4'd6,  13'b0100_11_00_00_000, 3'd0, 4'd0, 3'b001, 3'b001}, // R6 cooled
        {4'd3,  13'b0100_11_00_10_000, 3'd0, 4'd0, 3'b100, 3'b100}, // R3
        {4'd12, 13'b0100_11_00_00_010, 3'd0, 4'd0, 3'b000, 3'b000}, // R12 aux short
        {4'd12, 13'b0100_11_00_00_000, 3'd0, 4'd8, 3'b001, 3'b001}, // R12 recovered
        {4'd3,  13'b0100_11_00_10_000, 3'd0, 4'd0, 3'b100, 3'b100}, // R3
        {4'd6,  13'b0010_11_00_00_000, 3'd0, 4'd0, 3'b010, 3'b010}, // R6 supply low
        {4'd6,  13'b1010_11_00_00_000, 3'd0, 4'd0, 3'b000, 3'b000}, // R6 logic reset
        {4'd1,  13'b0100_11_00_00_000, 3'd0, 4'd0, 3'b001, 3'b001}, // R1 restart
        {4'd3,  13'b0100_11_00_10_000, 3'd0, 4'd0, 3'b100, 3'b100}, // R3
        {4'd12, 13'b0100_00_00_00_010, 3'd0, 4'd0, 3'b000, 3'b000}, // R12 aux while dim low
        {4'd12, 13'b0100_11_00_00_000, 3'd0, 4'd0, 3'b100, 3'b100}, // R12 ignored
        {4'd8,  13'b0100_11_00_00_100, 3'd4, 4'd0, 3'b000, 3'b000}, // R8 oc stop again
        {4'd9,  13'b0010_11_00_00_000, 3'd0, 4'd0, 3'b010, 3'b010}, // R9 supply unlatch
        {4'd2,  13'b0100_11_00_00_000, 3'd0, 4'd0, 3'b001, 3'b001}, // R2
        {4'd3,  13'b0100_11_00_10_000, 3'd0, 4'd0, 3'b100, 3'b100}, // R3
        {4'd7,  13'b0100_11_00_00_100, 3'd3, 4'd0, 3'b100, 3'b100}, // R7 three over
        {4'd10, 13'b0100_11_00_00_001, 3'd0, 4'd0, 3'b000, 3'b000}, // R10 leave run
        {4'd10, 13'b0100_11_00_00_000, 3'd0, 4'd6, 3'b001, 3'b001}, // R10 back to check
        {4'd3,  13'b0100_11_00_10_000, 3'd0, 4'd0, 3'b100, 3'b100}, // R3
        {4'd7,  13'b0100_11_00_00_100, 3'd1, 4'd0, 3'b100, 3'b100}  // R7 cleared on exit
    };

    task automatic check_out(input int req, input string tag, input logic [2:0] got,
                             input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d %s: got gate/sleep/imp=%b expected %b", req, tag, got, exp);
        end
    endtask

    task automatic set_inputs(input logic [12:0] v);
        {sup_rst, sup_on, sup_low, sup_ovp, dim_above, dim_above_hys, line_low, therm_hot,
         imp_done, imp_short, oc_stop, zcd_short, adj_ovp} = v;
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic [29:0] row;
        // R1 reset state
        repeat (3) @(negedge clk);
        check_out(1, "reset latched", {gate_l, sleep_l, imp_l}, 3'b000);
        check_out(1, "reset auto", {gate_a, sleep_a, imp_a}, 3'b000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            row = VEC[i];
            @(negedge clk);
            set_inputs(row[25:13]);
            repeat (2) @(negedge clk);
            for (int s = 0; s < int'(row[12:10]); s++) begin
                sw_cycle = 1'b1;
                @(negedge clk);
                sw_cycle = 1'b0;
                @(negedge clk);
            end
            for (int t = 0; t < int'(row[9:6]); t++) begin
                ms_tick = 1'b1;
                @(negedge clk);
                ms_tick = 1'b0;
                @(negedge clk);
            end
            repeat (2) @(negedge clk);
            check_out(int'(row[29:26]), $sformatf("step %0d latched", i),
                      {gate_l, sleep_l, imp_l}, row[5:3]);
            check_out(int'(row[29:26]), $sformatf("step %0d auto", i),
                      {gate_a, sleep_a, imp_a}, row[2:0]);
        end

        // R1 reset asserted while running clears all outputs at once
        set_inputs(13'b0100_11_00_00_000);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_out(1, "reset from run latched", {gate_l, sleep_l, imp_l}, 3'b000);
        check_out(1, "reset from run auto", {gate_a, sleep_a, imp_a}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_out(1, "restart after reset", {gate_l, sleep_l, imp_l}, 3'b001);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule